// File: doc/BRIEF.md
# Cascadable SDR/DDR Parallel-to-Serial Converter

This block turns a parallel word into a serial bit stream. It works with two phase-aligned clocks. On each rising edge of the slow word clock it captures a word of up to eight bits. On the next rising edge of the fast bit clock it loads that word into a shift register and starts sending it. In single-rate (SDR) mode it sends one bit per bit-clock cycle, and widths 2 to 8 are legal. In double-rate (DDR) mode it sends a pair of bits per bit-clock cycle on a rise output and a fall output, and widths 4, 6, 8, 10 and 14 are legal. The bit clock runs at width times the word rate in SDR mode and at width/2 times the word rate in DDR mode.

Widths 10 and 14 need two instances, one built as master and one as slave. Both are built with the same width, rate and clocks. The slave's cascade output drives the master's cascade input. The slave takes data only on its parallel inputs 3 to 8: inputs 3–4 for width 10 and inputs 3–8 for width 14. Its bits follow the master's eight bits in the stream.

A small controller has two states. `ST_IDLE` is entered on reset and holds every output at 0. When the first captured word arrives it takes the transition `IDLE_TO_RUN` and loads the shift register. `ST_RUN` then stays in place, with a load on each new word and a shift on every other cycle. Only reset leaves `ST_RUN`. The serial stream is also driven on a separate pair of feedback outputs, for loopback.

Top module: `ser_out_conv`

## Requirements
- R1: In SDR mode, parallel input 1 (par_in[0]) appears first on ser_rise, then inputs 2, 3 and so on, one bit per bit-clock cycle for WIDTH cycles.
- R2: In DDR mode, each bit-clock cycle presents one pair: ser_rise carries the odd-numbered input (par_in[2j]) and ser_fall the next even-numbered input (par_in[2j+1]), for WIDTH/2 cycles.
- R3: The first bit (or pair) of a word is visible right after the first bit-clock rising edge that follows the word-clock edge capturing it. The latency is one bit-clock cycle for every rate and width.
- R4: Words captured on consecutive word-clock edges are sent back to back, with no idle bit between them. Loads occur exactly every WIDTH (SDR) or WIDTH/2 (DDR) bit-clock cycles.
- R5: With a master/slave pair at width 10 or 14 in DDR mode, the master sends its inputs 1–8 first. The slave's inputs 3–4 (width 10) or 3–8 (width 14) follow, in ascending order, carried over casc_out → casc_in.
- R6: A slave ignores its parallel inputs 1 and 2 (par_in[1:0]); their values never reach the stream.
- R7: fb_rise and fb_fall always equal ser_rise and ser_fall.
- R8: During synchronous reset, and afterwards in ST_IDLE until the first word is loaded, ser_rise, ser_fall, the feedback outputs and casc_out are 0.
- R9: In SDR mode ser_fall stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Fast bit clock, phase-aligned to clk_word |
| clk_word | input | 1 | Slow word clock, captures par_in |
| rst | input | 1 | Synchronous reset, active high, sampled in both clock domains |
| par_in | input | 8 | Parallel word, bit 0 = input 1 (sent first) |
| casc_in | input | 2 | Bit pair from a slave's casc_out (tie to 0 when unused) |
| ser_rise | output | 1 | Serial output; the only bit in SDR, the first bit of a pair in DDR |
| ser_fall | output | 1 | Second bit of the DDR pair; 0 in SDR |
| fb_rise | output | 1 | Feedback copy of ser_rise |
| fb_fall | output | 1 | Feedback copy of ser_fall |
| casc_out | output | 2 | Lowest two shift-register bits, for a master's casc_in |

## Verification
Three configurations run side by side: SDR width 5, DDR width 8, and a DDR width-14 master/slave pair. Each is fed the same eight patterns: all ones, the two alternating patterns, a single low bit, a single high bit, and nibble and byte blocks. The walking single bits show bit order and first-bit latency. The alternating patterns separate the rise lane from the fall lane. The block patterns, followed without pause by the next word, expose gaps or overlap at word boundaries. In the cascade, the high-bit patterns show the slave's bits arriving after the master's, while the slave's inputs 1–2 carry the inverse of the stream bits to prove they are ignored.

// File: rtl/ser_out_pkg.sv
package ser_out_pkg;

    typedef enum logic {
        RATE_SDR = 1'b0,
        RATE_DDR = 1'b1
    } rate_e;

    typedef enum logic {
        ROLE_MASTER = 1'b0,
        ROLE_SLAVE  = 1'b1
    } role_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ctl_state_e;

    localparam int unsigned PAR_W  = 8;
    localparam int unsigned CASC_W = 2;
    localparam int unsigned SLAVE_SKIP = 2;  // slave inputs 1..2 unused

endpackage

// File: rtl/ser_word_capture.sv
// Word-clock domain: masks and aligns the parallel word, flags each capture.
module ser_word_capture
    import ser_out_pkg::*;
#(
    parameter role_e ROLE  = ROLE_MASTER,
    parameter int    WIDTH = 8
) (
    input  logic             clk_word,
    input  logic             rst,
    input  logic [PAR_W-1:0] par_in,
    output logic [PAR_W-1:0] word,
    output logic             word_tog
);

    localparam int KEEP = (ROLE == ROLE_SLAVE) ? (WIDTH - int'(PAR_W))
                        : ((WIDTH > int'(PAR_W)) ? int'(PAR_W) : WIDTH);
    localparam logic [PAR_W-1:0] KEEP_MASK = PAR_W'((1 << KEEP) - 1);

    logic [PAR_W-1:0] aligned;

    generate
        if (ROLE == ROLE_SLAVE) begin : g_slave
            assign aligned = {{SLAVE_SKIP{1'b0}}, par_in[PAR_W-1:SLAVE_SKIP]};
        end else begin : g_master
            assign aligned = par_in;
        end
    endgenerate

    always_ff @(posedge clk_word) begin
        if (rst) begin
            word     <= '0;
            word_tog <= 1'b0;
        end else begin
            word     <= aligned & KEEP_MASK;
            word_tog <= ~word_tog;
        end
    end

endmodule

// File: rtl/ser_load_ctrl.sv
// Bit-clock domain controller: spots a new word and sequences idle/run.
module ser_load_ctrl
    import ser_out_pkg::*;
(
    input  logic clk_bit,
    input  logic rst,
    input  logic word_tog,
    output logic load,
    output logic active
);

    ctl_state_e state, state_nx;
    logic       tog_seen;
    logic       arrive;

    assign arrive = (word_tog != tog_seen);

    always_ff @(posedge clk_bit) begin
        if (rst) begin
            state    <= ST_IDLE;
            tog_seen <= 1'b0;
        end else begin
            state    <= state_nx;
            tog_seen <= word_tog;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (arrive) state_nx = ST_RUN;   // IDLE_TO_RUN
            ST_RUN:  state_nx = ST_RUN;               // RUN_HOLD
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load   = arrive;
        active = (state == ST_RUN);
    end

endmodule

// File: rtl/ser_shift_reg.sv
// Bit-clock domain shift register, one or two bits per cycle.
module ser_shift_reg
    import ser_out_pkg::*;
#(
    parameter rate_e RATE = RATE_DDR
) (
    input  logic              clk_bit,
    input  logic              rst,
    input  logic              load,
    input  logic              active,
    input  logic [PAR_W-1:0]  word,
    input  logic [CASC_W-1:0] casc_in,
    output logic              q_rise,
    output logic              q_fall,
    output logic [CASC_W-1:0] casc_out
);

    logic [PAR_W-1:0] sr;
    logic [PAR_W-1:0] sr_shifted;

    always_comb begin
        sr_shifted = (RATE == RATE_DDR) ? {casc_in, sr[PAR_W-1:CASC_W]}
                                        : {casc_in[0], sr[PAR_W-1:1]};
    end

    always_ff @(posedge clk_bit) begin
        if (rst) begin
            sr <= '0;
        end else if (load) begin
            sr <= word;
        end else if (active) begin
            sr <= sr_shifted;
        end
    end

    always_comb begin
        q_rise   = active & sr[0];
        q_fall   = (RATE == RATE_DDR) ? (active & sr[1]) : 1'b0;
        casc_out = active ? sr[CASC_W-1:0] : '0;
    end

endmodule

// File: rtl/ser_out_conv.sv
// Top: cascadable SDR/DDR parallel-to-serial converter.
module ser_out_conv
    import ser_out_pkg::*;
#(
    parameter rate_e RATE  = RATE_DDR,
    parameter int    WIDTH = 8,
    parameter role_e ROLE  = ROLE_MASTER
) (
    input  logic              clk_bit,
    input  logic              clk_word,
    input  logic              rst,
    input  logic [PAR_W-1:0]  par_in,
    input  logic [CASC_W-1:0] casc_in,
    output logic              ser_rise,
    output logic              ser_fall,
    output logic              fb_rise,
    output logic              fb_fall,
    output logic [CASC_W-1:0] casc_out
);

    logic [PAR_W-1:0] cap_word;
    logic             cap_tog;
    logic             load;
    logic             active;

    ser_word_capture #(.ROLE(ROLE), .WIDTH(WIDTH)) u_capture (
        .clk_word (clk_word),
        .rst      (rst),
        .par_in   (par_in),
        .word     (cap_word),
        .word_tog (cap_tog)
    );

    ser_load_ctrl u_ctrl (
        .clk_bit  (clk_bit),
        .rst      (rst),
        .word_tog (cap_tog),
        .load     (load),
        .active   (active)
    );

    ser_shift_reg #(.RATE(RATE)) u_shift (
        .clk_bit  (clk_bit),
        .rst      (rst),
        .load     (load),
        .active   (active),
        .word     (cap_word),
        .casc_in  (casc_in),
        .q_rise   (ser_rise),
        .q_fall   (ser_fall),
        .casc_out (casc_out)
    );

    assign fb_rise = ser_rise;
    assign fb_fall = ser_fall;

endmodule

// File: rtl/ser_out_conv_chk.sv
module ser_out_conv_chk
    import ser_out_pkg::*;
#(
    parameter rate_e RATE  = RATE_DDR,
    parameter int    WIDTH = 8
) (
    input logic              clk_bit,
    input logic              rst,
    input logic              load,
    input logic              active,
    input logic [PAR_W-1:0]  cap_word,
    input logic              ser_rise,
    input logic              ser_fall,
    input logic [CASC_W-1:0] casc_out
);

    localparam int CYC = (RATE == RATE_DDR) ? (WIDTH / 2) : WIDTH;

    logic [7:0] gap;
    logic       seen;

    always_ff @(posedge clk_bit) begin
        if (rst) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (load) begin
            gap  <= '0;
            seen <= 1'b1;
        end else if (gap != 8'hFF) begin
            gap <= gap + 8'd1;
        end
    end

    // R3: first bit follows the load edge
    assert_first_bit_R3: assert property (@(posedge clk_bit) disable iff (rst)
        load |=> (ser_rise == $past(cap_word[0])));

    // R2: DDR fall lane carries input 2 in the first pair
    assert_first_pair_R2: assert property (@(posedge clk_bit) disable iff (rst)
        (load && RATE == RATE_DDR) |=> (ser_fall == $past(cap_word[1])));

    // R8: quiet outputs until the first load
    assert_idle_quiet_R8: assert property (@(posedge clk_bit) disable iff (rst)
        !active |-> (!ser_rise && !ser_fall && casc_out == '0));

    // R4: loads spaced exactly one word period apart
    assert_word_period_R4: assert property (@(posedge clk_bit) disable iff (rst)
        (load && seen) |-> (gap == 8'(CYC - 1)));

endmodule

bind ser_out_conv ser_out_conv_chk #(.RATE(RATE), .WIDTH(WIDTH)) u_chk (
    .clk_bit  (clk_bit),
    .rst      (rst),
    .load     (load),
    .active   (active),
    .cap_word (cap_word),
    .ser_rise (ser_rise),
    .ser_fall (ser_fall),
    .casc_out (casc_out)
);

// File: tb/test_ser_out_conv.sv
module test_ser_out_conv;
    import ser_out_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NWORDS = 8;
    localparam logic [13:0] VEC [0:NWORDS-1] = '{
        14'h3FFF, 14'h2AAA, 14'h1555, 14'h0001,
        14'h2000, 14'h0F0F, 14'h3C3C, 14'h00FF
    };

    logic clk = 1'b0;
    logic wclk_a = 1'b0, wclk_b = 1'b0, wclk_c = 1'b0;
    logic rst = 1'b1;
    logic [7:0] par_a = '0, par_b = '0, par_m = '0, par_s = '0;
    logic ra, fa, fra, ffa, rb, fb, frb, ffb, rm, fm, frm, ffm, rs, fs, frs, ffs;
    logic [1:0] co_a, co_b, co_m, co_s;
    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    initial begin #(CLK_PERIOD/2); forever begin wclk_a = 1'b1; #(5*CLK_PERIOD/2); wclk_a = 1'b0; #(5*CLK_PERIOD/2); end end
    initial begin #(CLK_PERIOD/2); forever begin wclk_b = 1'b1; #(4*CLK_PERIOD/2); wclk_b = 1'b0; #(4*CLK_PERIOD/2); end end
    initial begin #(CLK_PERIOD/2); forever begin wclk_c = 1'b1; #(7*CLK_PERIOD/2); wclk_c = 1'b0; #(7*CLK_PERIOD/2); end end

    ser_out_conv #(.RATE(RATE_SDR), .WIDTH(5), .ROLE(ROLE_MASTER)) i_ser_out_conv (
        .clk_bit(clk), .clk_word(wclk_a), .rst(rst), .par_in(par_a), .casc_in(2'b00),
        .ser_rise(ra), .ser_fall(fa), .fb_rise(fra), .fb_fall(ffa), .casc_out(co_a));

    ser_out_conv #(.RATE(RATE_DDR), .WIDTH(8), .ROLE(ROLE_MASTER)) i_ddr8 (
        .clk_bit(clk), .clk_word(wclk_b), .rst(rst), .par_in(par_b), .casc_in(2'b00),
        .ser_rise(rb), .ser_fall(fb), .fb_rise(frb), .fb_fall(ffb), .casc_out(co_b));

    ser_out_conv #(.RATE(RATE_DDR), .WIDTH(14), .ROLE(ROLE_MASTER)) i_mst (
        .clk_bit(clk), .clk_word(wclk_c), .rst(rst), .par_in(par_m), .casc_in(co_s),
        .ser_rise(rm), .ser_fall(fm), .fb_rise(frm), .fb_fall(ffm), .casc_out(co_m));

    ser_out_conv #(.RATE(RATE_DDR), .WIDTH(14), .ROLE(ROLE_SLAVE)) i_slv (
        .clk_bit(clk), .clk_word(wclk_c), .rst(rst), .par_in(par_s), .casc_in(2'b00),
        .ser_rise(rs), .ser_fall(fs), .fb_rise(frs), .fb_fall(ffs), .casc_out(co_s));

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] outs(input int d);
        case (d)
            0:       return {ra, fa, fra, ffa};
            1:       return {rb, fb, frb, ffb};
            default: return {rm, fm, frm, ffm};
        endcase
    endfunction

    task automatic wait_wneg(input int d);
        case (d)
            0:       @(negedge wclk_a);
            1:       @(negedge wclk_b);
            default: @(negedge wclk_c);
        endcase
    endtask

    task automatic wait_wpos(input int d);
        case (d)
            0:       @(posedge wclk_a);
            1:       @(posedge wclk_b);
            default: @(posedge wclk_c);
        endcase
    endtask

    task automatic drive(input int d);
        for (int k = 0; k < NWORDS; k++) begin
            wait_wneg(d);
            case (d)
                0: par_a = {3'b101, VEC[k][4:0]};
                1: par_b = VEC[k][7:0];
                default: begin
                    par_m = VEC[k][7:0];
                    par_s = {VEC[k][13:8], ~VEC[k][1:0]};  // R6: inputs 1-2 garbage
                end
            endcase
        end
    endtask

    task automatic stream(input int d, input int cyc);
        logic [3:0] act;
        logic er, ef;
        string tag;
        wait_wneg(d);
        wait_wpos(d);
        #1;
        @(posedge clk);
        for (int n = 0; n < NWORDS * cyc; n++) begin
            int k;
            int s;
            @(negedge clk);
            k = n / cyc;
            s = n % cyc;
            if (d == 0) begin
                er = VEC[k][s];
                ef = 1'b0;
                tag = "R1 R9";
            end else begin
                er = VEC[k][2*s];
                ef = VEC[k][2*s+1];
                tag = (d == 1) ? "R2" : "R5 R6";
            end
            if (s == 0) tag = {tag, " R3 R4"};
            act = outs(d);
            check($sformatf("%s dut%0d word%0d slot%0d", tag, d, k, s), {2'b00, act[3:2]}, {2'b00, er, ef});
            check($sformatf("R7 dut%0d", d), {2'b00, act[1:0]}, {2'b00, act[3:2]});
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        par_a = 8'hFF; par_b = 8'hFF; par_m = 8'hFF; par_s = 8'hFF;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            check("R8 reset sdr/ddr", {ra, fa, rb, fb}, 4'b0000);
            check("R8 reset cascade", {rm, fm, co_m}, 4'b0000);
        end
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R8 idle after reset", {ra, fa, rb, fb}, 4'b0000);
        check("R8 idle cascade", {rm, fm, co_s}, 4'b0000);
        fork
            drive(0);
            stream(0, 5);
            drive(1);
            stream(1, 4);
            drive(2);
            stream(2, 7);
        join
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule